// File: doc/BRIEF.md
# Two-way write-back data cache with parked victim

The block is a two-way set-associative data cache between a CPU port and a slower memory. It uses a write-back, write-allocate policy. Loads and stores give an address, byte enables and write data, and stay presented while the cache holds them off. Lookups finish in the cycle they are presented: hit and read data come back in that same cycle. On a miss the cache stalls the CPU, fetches the whole block from memory and installs it, and then finishes the request as a hit.

When the way being replaced holds modified data, that block is parked in a one-entry writeback buffer. The fill request therefore goes out first. The parked block is offered to memory only once the new block is installed. Memory traffic uses two valid/ready channels that send requests out (fill request, writeback) and one valid/ready channel that brings the response in (fill data). A valid, once raised, holds its payload stable until ready is seen high at a clock edge. The cache keeps fill_rsp_ready high only while it waits for a fill. Memory may hold any ready low for as long as it likes, and the cache simply stalls.

Top module: `wb2way_cache`

## Requirements
- R1: A byte address splits, from bit 0 upward, into a 4-bit block offset (bits 3:2 pick the 32-bit word), a 3-bit set index (bits 6:4) and a 5-bit tag (bits 11:7). Addresses that differ only in the offset share one block.
- R2: A presented request hits when either way of its set is valid with an equal tag. In that same cycle cpu_hit is 1, cpu_stall is 0, and a load returns the addressed word.
- R3: Each set keeps one least-recently-used way bit, updated on every completed access (hits included) to point away from the way used. A miss replaces the way that bit names.
- R4: A miss raises cpu_stall from its first cycle until the fill is installed. The held request then completes as a hit.
- R5: A fill request carries the block-aligned miss address and holds valid and address until accepted.
- R6: A store writes only the byte lanes enabled in cpu_be of the addressed word, only in the matching way, and marks that block modified.
- R7: A store miss allocates: the block is fetched, then the store data is merged into it.
- R8: Replacing an unmodified block sends nothing to memory. Replacing a modified block sends the whole block, with its own address, exactly once.
- R9: With a modified victim, the fill request is issued first and the victim is parked. wb_valid rises only in the cycle after the fill data is accepted.
- R10: While the buffer still holds an undrained block, a miss whose victim is modified, or a miss on the parked block itself, stalls until the buffer empties.
- R11: After reset every block is invalid and unmodified and every LRU bit names way 0, so the first access to any set misses and fills way 0.
- R12: wb_valid, wb_addr and wb_data hold until wb_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request presented; held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 12 | Byte address |
| cpu_be | input | 4 | Store byte lane enables |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_hit |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request must be held |
| fill_req_valid | output | 1 | Block fetch request |
| fill_req_ready | input | 1 | Memory accepts fetch request |
| fill_req_addr | output | 12 | Block-aligned fetch address |
| fill_rsp_valid | input | 1 | Fetched block present |
| fill_rsp_ready | output | 1 | Cache accepts fetched block |
| fill_rsp_data | input | 128 | Fetched block, word 0 in the low bits |
| wb_valid | output | 1 | Writeback block offered |
| wb_ready | input | 1 | Memory accepts writeback |
| wb_addr | output | 12 | Block-aligned writeback address |
| wb_data | output | 128 | Writeback block |

## Verification
Draining the parked block and serving the CPU can happen in the same cycle. The draining block may coincide with a hit, with a fresh fill request for a clean victim, or with a miss on the very block still waiting in the buffer. Random ready patterns on all three memory channels make these overlaps happen. A directed case also holds wb_ready low across a re-fetch of the parked block. The bench judges the results against a golden memory image: every fetched block must already hold the latest stored bytes, every writeback must match the image, and the re-fetch must stay stalled until the drain.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_REQ    = 2'd1,
    ST_WAIT   = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
`timescale 1ns/1ps
module wbc_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 5,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       way_hit,
  output logic             lru_way,
  output logic [TAG_W-1:0] vic_tag,
  output logic             vic_dirty,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             dirty_en,
  input  logic             dirty_way,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int WAYS = 2;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
  end

  assign lru_way   = lru_q[idx];
  assign vic_tag   = tag_q[idx][lru_way];
  assign vic_dirty = valid_q[idx][lru_way] && dirty_q[idx][lru_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
      lru_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[idx][fill_way] <= 1'b1;
        dirty_q[idx][fill_way] <= 1'b0;
      end
      if (dirty_en) dirty_q[idx][dirty_way] <= 1'b1;
      if (touch_en) lru_q[idx] <= ~touch_way;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx][fill_way] <= fill_tag;
  end

  // at most one way may claim a given tag
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));
  // a block is only installed where it is not already present
  p_fill_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (way_hit == 2'b00));
  // a set's LRU bit moves away from the way just used
  p_lru_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(idx)] != $past(touch_way)));
endmodule

// File: rtl/wbc_data_store.sv
`timescale 1ns/1ps
module wbc_data_store #(
  parameter int SETS   = 8,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(SETS),
  parameter int WSEL_W = $clog2(WORDS),
  parameter int BLK_W  = DATA_W * WORDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    idx,
  input  logic                rd_way,
  output logic [BLK_W-1:0]    rd_blk,
  input  logic                st_en,
  input  logic                st_way,
  input  logic [WSEL_W-1:0]   st_word,
  input  logic [DATA_W/8-1:0] st_be,
  input  logic [DATA_W-1:0]   st_wdata,
  input  logic                fill_en,
  input  logic                fill_way,
  input  logic [BLK_W-1:0]    fill_blk
);
  localparam int LANES = DATA_W / 8;

  logic [BLK_W-1:0] data_q [SETS][2];
  logic [BLK_W-1:0] cur_blk;
  logic [BLK_W-1:0] merged;

  assign rd_blk  = data_q[idx][rd_way];
  assign cur_blk = data_q[idx][st_way];

  for (genvar b = 0; b < BLK_W / 8; b++) begin : g_lane
    assign merged[b*8 +: 8] =
      (st_word == WSEL_W'(b / LANES) && st_be[b % LANES]) ?
        st_wdata[(b % LANES)*8 +: 8] : cur_blk[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (fill_en)    data_q[idx][fill_way] <= fill_blk;
    else if (st_en) data_q[idx][st_way]   <= merged;
  end

  // a store and a fill never target the array in one cycle
  p_no_dual_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && st_en));
endmodule

// File: rtl/wbc_wb_buffer.sv
`timescale 1ns/1ps
module wbc_wb_buffer #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 4,
  parameter int BLK_W  = 128,
  parameter int BLKA_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_en,
  input  logic [BLKA_W-1:0] park_addr,
  input  logic [BLK_W-1:0]  park_blk,
  input  logic              arm_en,
  output logic              full,
  output logic [BLKA_W-1:0] held_addr,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [BLK_W-1:0]  wb_data
);
  logic              full_q, go_q;
  logic [BLKA_W-1:0] addr_q;
  logic [BLK_W-1:0]  blk_q;

  assign full      = full_q;
  assign held_addr = addr_q;
  assign wb_valid  = go_q;
  assign wb_addr   = {addr_q, {OFF_W{1'b0}}};
  assign wb_data   = blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      if (go_q && wb_ready) begin
        full_q <= 1'b0;
        go_q   <= 1'b0;
      end
      if (park_en) full_q <= 1'b1;
      if (arm_en && full_q) go_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (park_en) begin
      addr_q <= park_addr;
      blk_q  <= park_blk;
    end
  end

  p_park_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> !full_q);
  p_wb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
endmodule

// File: rtl/wb2way_cache.sv
`timescale 1ns/1ps
module wb2way_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 8,
  localparam int BLK_W = DATA_W * WORDS,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [LANES-1:0]  cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  output logic              fill_rsp_ready,
  input  logic [BLK_W-1:0]  fill_rsp_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [BLK_W-1:0]  wb_data
);
  import wbc_pkg::*;

  localparam int BYTE_OFF = $clog2(LANES);
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int OFF_W    = BYTE_OFF + WSEL_W;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int BLKA_W   = ADDR_W - OFF_W;

  wbc_state_e        state_q;
  logic [BLKA_W-1:0] miss_blk_q;
  logic              miss_way_q, miss_dirty_q;
  logic [TAG_W-1:0]  vic_tag_q;

  logic [IDX_W-1:0]  cur_idx, lk_idx;
  logic [TAG_W-1:0]  cur_tag, lk_tag;
  logic [WSEL_W-1:0] cur_word;
  logic              in_lookup, any_hit, hit_way, lk_hit, lk_miss;
  logic              wbb_conflict, start_miss, req_fire, rsp_fire;
  logic [1:0]        way_hit;
  logic              lru_way, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic [BLK_W-1:0]  rd_blk;
  logic              wbb_full;
  logic [BLKA_W-1:0] wbb_addr;
  logic              unused_lo;

  assign unused_lo = ^cpu_addr[BYTE_OFF-1:0];

  assign cur_word  = cpu_addr[BYTE_OFF +: WSEL_W];
  assign cur_idx   = cpu_addr[OFF_W +: IDX_W];
  assign cur_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  assign in_lookup = (state_q == ST_LOOKUP);
  assign lk_idx    = in_lookup ? cur_idx : miss_blk_q[IDX_W-1:0];
  assign lk_tag    = in_lookup ? cur_tag : miss_blk_q[BLKA_W-1 -: TAG_W];

  assign any_hit = |way_hit;
  assign hit_way = way_hit[1];
  assign lk_hit  = in_lookup && cpu_valid && any_hit;
  assign lk_miss = in_lookup && cpu_valid && !any_hit;

  assign wbb_conflict = wbb_full && (vic_dirty || (wbb_addr == {cur_tag, cur_idx}));
  assign start_miss   = lk_miss && !wbb_conflict;

  assign fill_req_valid = (state_q == ST_REQ);
  assign fill_req_addr  = {miss_blk_q, {OFF_W{1'b0}}};
  assign fill_rsp_ready = (state_q == ST_WAIT);
  assign req_fire       = fill_req_valid && fill_req_ready;
  assign rsp_fire       = fill_rsp_ready && fill_rsp_valid;

  assign cpu_hit   = lk_hit;
  assign cpu_stall = cpu_valid && !lk_hit;
  assign cpu_rdata = rd_blk[cur_word*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_LOOKUP;
      miss_blk_q   <= '0;
      miss_way_q   <= 1'b0;
      miss_dirty_q <= 1'b0;
      vic_tag_q    <= '0;
    end else begin
      case (state_q)
        ST_LOOKUP: if (start_miss) begin
          miss_blk_q   <= {cur_tag, cur_idx};
          miss_way_q   <= lru_way;
          miss_dirty_q <= vic_dirty;
          vic_tag_q    <= vic_tag;
          state_q      <= ST_REQ;
        end
        ST_REQ:  if (req_fire) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_fire) state_q <= ST_LOOKUP;
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  wbc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (lk_idx),
    .tag       (lk_tag),
    .way_hit   (way_hit),
    .lru_way   (lru_way),
    .vic_tag   (vic_tag),
    .vic_dirty (vic_dirty),
    .touch_en  (lk_hit),
    .touch_way (hit_way),
    .dirty_en  (lk_hit && cpu_we),
    .dirty_way (hit_way),
    .fill_en   (rsp_fire),
    .fill_way  (miss_way_q),
    .fill_tag  (lk_tag)
  );

  wbc_data_store #(.SETS(SETS), .DATA_W(DATA_W), .WORDS(WORDS)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (lk_idx),
    .rd_way   (in_lookup ? hit_way : miss_way_q),
    .rd_blk   (rd_blk),
    .st_en    (lk_hit && cpu_we),
    .st_way   (hit_way),
    .st_word  (cur_word),
    .st_be    (cpu_be),
    .st_wdata (cpu_wdata),
    .fill_en  (rsp_fire),
    .fill_way (miss_way_q),
    .fill_blk (fill_rsp_data)
  );

  wbc_wb_buffer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_W(BLK_W)) u_wbb (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_en   (req_fire && miss_dirty_q),
    .park_addr ({vic_tag_q, miss_blk_q[IDX_W-1:0]}),
    .park_blk  (rd_blk),
    .arm_en    (rsp_fire && miss_dirty_q),
    .full      (wbb_full),
    .held_addr (wbb_addr),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data)
  );

  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));
  p_wb_after_install_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(fill_rsp_valid && fill_rsp_ready));
  p_refill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && cpu_valid) |=> (cpu_hit || !cpu_valid));
  p_no_fill_while_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid || fill_rsp_ready) |-> (cpu_stall || !cpu_valid));
endmodule

// File: tb/sim_wb2way_cache.sv
`timescale 1ns/1ps
module sim_wb2way_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [11:0]  cpu_addr = '0;
  logic [3:0]   cpu_be = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_hit, cpu_stall;
  logic         fill_req_valid, fill_req_ready = 1'b0;
  logic [11:0]  fill_req_addr;
  logic         fill_rsp_valid = 1'b0, fill_rsp_ready;
  logic [127:0] fill_rsp_data = '0;
  logic         wb_valid, wb_ready = 1'b0;
  logic [11:0]  wb_addr;
  logic [127:0] wb_data;

  always #2 clk = ~clk;

  wb2way_cache u0 (.*);

  int errors = 0, checks = 0;
  int cyc = 0, last_rsp_cyc = -10, wb_cnt = 0, exp_wb = 0;
  bit wb_hold = 1'b0, wb_prev = 1'b0, done = 1'b0;
  logic [127:0] mem  [256];
  logic [127:0] gold [256];
  logic [4:0]   mt [8][2];
  logic [1:0]   mv [8], md [8];
  logic         mlru [8];

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model: fetch, writeback, and handshake-hold checks
  initial begin
    bit pend = 0, freq_h = 0, wb_h = 0;
    int lat = 0, pblk = 0;
    logic [11:0] freq_a = '0, wb_a = '0;
    forever begin
      @(posedge clk);
      cyc++;
      if (freq_h) chk(fill_req_valid && fill_req_addr == freq_a, "R5", {fill_req_valid, fill_req_addr}, {1'b1, freq_a});
      if (wb_h)   chk(wb_valid && wb_addr == wb_a, "R12", {wb_valid, wb_addr}, {1'b1, wb_a});
      freq_h = fill_req_valid && !fill_req_ready; freq_a = fill_req_addr;
      wb_h   = wb_valid && !wb_ready;             wb_a   = wb_addr;
      if (fill_rsp_valid && fill_rsp_ready) begin
        fill_rsp_valid <= 1'b0;
        last_rsp_cyc = cyc;
      end
      if (fill_req_valid && fill_req_ready) begin
        chk(fill_req_addr[3:0] == 4'h0, "R5", fill_req_addr, {fill_req_addr[11:4], 4'h0});
        pend = 1; pblk = int'(fill_req_addr[11:4]); lat = 1 + int'($urandom % 4);
      end else if (pend) begin
        lat--;
        if (lat == 0) begin
          chk(mem[pblk] == gold[pblk], "R10", mem[pblk], gold[pblk]);
          fill_rsp_valid <= 1'b1;
          fill_rsp_data  <= mem[pblk];
          pend = 0;
        end
      end
      if (wb_valid && wb_ready) begin
        chk(wb_data == gold[wb_addr[11:4]], "R8", wb_data, gold[wb_addr[11:4]]);
        mem[wb_addr[11:4]] = wb_data;
        wb_cnt++;
      end
      fill_req_ready <= ($urandom % 3) != 0;
      wb_ready       <= wb_hold ? 1'b0 : (($urandom % 3) != 0);
    end
  end

  // writeback must start right after a fill has been installed
  initial forever begin
    @(negedge clk);
    if (rst_n && wb_valid && !wb_prev)
      chk(last_rsp_cyc == cyc, "R9", 128'(last_rsp_cyc), 128'(cyc));
    wb_prev = wb_valid;
  end

  task automatic access(input bit we, input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output int stalls);
    int s = int'(a[6:4]);
    int blk = int'(a[11:4]);
    int wi = int'(a[3:2]);
    logic [4:0] tg = a[11:7];
    bit h0, h1, eh, way;
    h0 = mv[s][0] && mt[s][0] == tg;
    h1 = mv[s][1] && mt[s][1] == tg;
    eh = h0 || h1;
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    @(negedge clk);
    chk(cpu_hit == eh, "R2", cpu_hit, eh);
    stalls = 0;
    while (cpu_stall && stalls < 3000) begin
      stalls++;
      @(negedge clk);
    end
    chk(!cpu_stall && cpu_hit, "R4", {cpu_stall, cpu_hit}, 2'b01);
    if (!we) chk(cpu_rdata == gold[blk][wi*32 +: 32], "R6", cpu_rdata, gold[blk][wi*32 +: 32]);
    else for (int b = 0; b < 4; b++)
      if (be[b]) gold[blk][wi*32 + b*8 +: 8] = wd[b*8 +: 8];
    if (eh) way = h1;
    else begin
      way = mlru[s];
      if (mv[s][way] && md[s][way]) exp_wb++;
      mt[s][way] = tg; mv[s][way] = 1'b1; md[s][way] = 1'b0;
    end
    mlru[s] = ~way;
    if (we) md[s][way] = 1'b1;
    @(posedge clk); #1;
    cpu_valid = 1'b0;
  endtask

  initial begin
    int st, base;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 256; b++) begin
      for (int w = 0; w < 4; w++) mem[b][w*32 +: 32] = {b[7:0], w[7:0], 16'h5A00 + 16'(b)};
      gold[b] = mem[b];
    end
    for (int s = 0; s < 8; s++) begin mv[s] = '0; md[s] = '0; mlru[s] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({cpu_stall, fill_req_valid, wb_valid} == 3'b000, "R11", {cpu_stall, fill_req_valid, wb_valid}, 3'b000);

    access(0, 12'h000, 4'h0, 0, st);            // R11 cold miss fills way 0
    chk(st > 0, "R11", st, 1);
    access(0, 12'h004, 4'h0, 0, st);            // R1 same block, other word
    chk(st == 0, "R1", st, 0);
    access(0, 12'h010, 4'h0, 0, st);            // R1 next index misses
    chk(st > 0, "R1", st, 1);
    access(1, 12'h008, 4'h3, 32'hDEADBEEF, st); // R6 two lanes
    access(0, 12'h008, 4'h0, 0, st);
    access(0, 12'h080, 4'h0, 0, st);            // R3 same set into way 1
    access(0, 12'h000, 4'h0, 0, st);            // R3 way 0 intact
    chk(st == 0, "R3", st, 0);
    base = wb_cnt;
    access(0, 12'h100, 4'h0, 0, st);            // R8 evicts clean 0x080
    repeat (15) @(negedge clk);
    chk(wb_cnt == base, "R8", wb_cnt, base);
    access(0, 12'h180, 4'h0, 0, st);            // R8 evicts dirty 0x000
    repeat (30) @(negedge clk);
    chk(wb_cnt == base + 1, "R8", wb_cnt, base + 1);
    access(1, 12'h204, 4'hF, 32'h12345678, st); // R7 store miss allocates
    chk(st > 0, "R7", st, 1);
    access(0, 12'h204, 4'h0, 0, st);
    chk(st == 0, "R7", st, 0);

    // R10: re-fetch of a parked block while its drain is held back
    access(1, 12'h020, 4'hF, 32'hA1A2A3A4, st);
    access(1, 12'h0A0, 4'hF, 32'hB1B2B3B4, st);
    wb_hold = 1'b1;
    access(0, 12'h120, 4'h0, 0, st);
    fork
      begin repeat (40) @(posedge clk); wb_hold = 1'b0; end
    join_none
    access(0, 12'h020, 4'h0, 0, st);
    chk(st >= 35, "R10", st, 35);

    for (int i = 0; i < 1500; i++) begin
      logic [11:0] a;
      a = {3'($urandom % 4), 2'b00, 3'($urandom % 8), 2'($urandom % 4), 2'b00};
      a[11:10] = 2'b00; a[8:7] = 2'($urandom % 4);
      access(bit'($urandom % 2), a, 4'($urandom), $urandom, st);
    end
    repeat (60) @(negedge clk);
    chk(!wb_valid && wb_cnt == exp_wb, "R8", wb_cnt, exp_wb);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule